// File: doc/BRIEF.md
# Floating-Point Reservation Station Array

This block holds a small set of waiting floating-point operations in an out-of-order core. Each station takes one operation at dispatch, together with two source operands. A source arrives either as a finished value or as the tag of the unit that will produce it. Tag zero means "value present". Stations that are still waiting watch one shared result broadcast bus. When the tag on the bus matches a missing source, the station copies the broadcast value. Every matching field in every station does this in the same clock cycle.

Once both sources of a station are present, the station can be sent to execution. If several stations are ready, the lowest-numbered one goes first, and only one goes per cycle. The chosen operation and its two values leave the block on a registered execute port. An external execution stub later places the result on the broadcast bus under the station's own tag (1 to N). That broadcast feeds any consumers of the result and also frees the station.

New dispatches always go to the lowest-numbered free station, and the block reports which tag it assigned. A dispatch that arrives in the same cycle as the broadcast it depends on picks up the value straight from the bus.

Top module: `rs_array`

## Requirements
- R1: `disp_ready` is high exactly when at least one station is free. `disp_tag` then shows the tag (1..N) of the lowest-numbered free station, and that station takes the next dispatch. When every station is busy, `disp_tag` reads 0.
- R2: For each source, a zero tag at dispatch makes the station store the supplied value. A nonzero tag makes the station store the tag and wait for a broadcast.
- R3: A station is never sent to execution while either of its source tags is nonzero.
- R4: A broadcast with nonzero tag t fills every waiting source field that holds t, across all stations and both operands, on the same clock edge.
- R5: Suppose a broadcast is sampled at edge k and a station becomes ready as a result. If that station is the lowest-numbered ready station, `ex_valid` carries it after edge k+1. A station dispatched with both values present at edge k likewise appears after edge k+1.
- R6: Suppose a dispatched source carries tag t and a broadcast with tag t is on the bus in the same cycle. The station stores the broadcast data and does not wait.
- R7: When several stations are ready, they go to execution in ascending station order, one per cycle. `ex_tag` shows the station number, and `ex_op`, `ex_vj` and `ex_vk` show its contents.
- R8: A station is sent to execution once only. It stays busy until a broadcast carries its own tag, and then becomes free on that edge.
- R9: After reset every station is free and `ex_valid` is low.
- R10: A dispatch presented while `disp_ready` is low is ignored, and no station changes.
- R11: A broadcast with tag 0 changes no station.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | OP_W | Operation code |
| disp_qj | input | TAG_W | Producer tag of first source, 0 = value present |
| disp_vj | input | DATA_W | First source value |
| disp_qk | input | TAG_W | Producer tag of second source, 0 = value present |
| disp_vk | input | DATA_W | Second source value |
| disp_ready | output | 1 | A station is free |
| disp_tag | output | TAG_W | Tag the next dispatch will receive, 0 when full |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | TAG_W | Tag of the producer being broadcast |
| cdb_data | input | DATA_W | Broadcast result value |
| ex_valid | output | 1 | Execute request, one cycle per station |
| ex_tag | output | TAG_W | Station number being executed |
| ex_op | output | OP_W | Operation code |
| ex_vj | output | DATA_W | First operand |
| ex_vk | output | DATA_W | Second operand |

## Verification
A wrong tag or a missed snoop usually shows up as a station that never issues. In that case `ex_valid` stays low one cycle past the edge where the issue was due, and `disp_ready` later stays low because the station never frees. A stale or wrongly overwritten operand shows on `ex_vj` or `ex_vk` in the very cycle the station issues. Broken ordering or a repeated issue shows in the next `ex_tag` value. The checks therefore sample the execute port exactly one edge after each wakeup or dispatch, and read the tag offered for dispatch after every free.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned DEF_ENTRIES = 4;
  localparam int unsigned DEF_DATA_W  = 32;
  localparam int unsigned DEF_OP_W    = 4;

  // tag 0 is reserved for "value present", stations use 1..n
  function automatic int unsigned tag_bits(input int unsigned n);
    return $clog2(n + 1);
  endfunction

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = rs_pkg::idx_bits(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic found;

  always_comb begin
    gnt   = '0;
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        idx    = IW'(i);
        found  = 1'b1;
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/rs_entry.sv
module rs_entry #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OP_W   = 4,
  parameter int unsigned TAG_W  = 3,
  parameter int unsigned MY_TAG = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc,
  input  logic [OP_W-1:0]   d_op,
  input  logic [TAG_W-1:0]  d_qj,
  input  logic [DATA_W-1:0] d_vj,
  input  logic [TAG_W-1:0]  d_qk,
  input  logic [DATA_W-1:0] d_vk,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic              issue,
  output logic              busy_o,
  output logic              ready_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] vj_o,
  output logic [DATA_W-1:0] vk_o
);
  logic              busy, issued;
  logic [TAG_W-1:0]  qj, qk;
  logic [OP_W-1:0]   op;
  logic [DATA_W-1:0] vj, vk;

  logic bus_live, hit_dj, hit_dk, snp_j, snp_k, free_me;

  assign bus_live = cdb_valid && (cdb_tag != '0);
  assign hit_dj   = bus_live && (d_qj == cdb_tag);
  assign hit_dk   = bus_live && (d_qk == cdb_tag);
  assign snp_j    = bus_live && (qj == cdb_tag);
  assign snp_k    = bus_live && (qk == cdb_tag);
  assign free_me  = busy && bus_live && (cdb_tag == TAG_W'(MY_TAG));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      issued <= 1'b0;
      qj     <= '0;
      qk     <= '0;
    end else if (alloc) begin
      busy   <= 1'b1;
      issued <= 1'b0;
      op     <= d_op;
      if (d_qj == '0) begin
        qj <= '0;
        vj <= d_vj;
      end else if (hit_dj) begin
        qj <= '0;
        vj <= cdb_data;
      end else begin
        qj <= d_qj;
      end
      if (d_qk == '0) begin
        qk <= '0;
        vk <= d_vk;
      end else if (hit_dk) begin
        qk <= '0;
        vk <= cdb_data;
      end else begin
        qk <= d_qk;
      end
    end else begin
      if (free_me) begin
        busy   <= 1'b0;
        issued <= 1'b0;
      end else if (issue) begin
        issued <= 1'b1;
      end
      if (snp_j) begin
        qj <= '0;
        vj <= cdb_data;
      end
      if (snp_k) begin
        qk <= '0;
        vk <= cdb_data;
      end
    end
  end

  assign busy_o  = busy;
  assign ready_o = busy && !issued && (qj == '0) && (qk == '0);
  assign op_o    = op;
  assign vj_o    = vj;
  assign vk_o    = vk;

  // R1: dispatch lands only on a free station
  a_r1_alloc_free: assert property (@(posedge clk) disable iff (rst)
    alloc |-> !busy);
  // R3: the selector grants only stations whose sources are present
  a_r3_issue_needs_ops: assert property (@(posedge clk) disable iff (rst)
    issue |-> (busy && !issued && qj == '0 && qk == '0));
  // R4: snooped fields are filled with the bus value
  a_r4_snoop_j: assert property (@(posedge clk) disable iff (rst)
    (busy && !alloc && snp_j) |=> (qj == '0 && vj == $past(cdb_data)));
  a_r4_snoop_k: assert property (@(posedge clk) disable iff (rst)
    (busy && !alloc && snp_k) |=> (qk == '0 && vk == $past(cdb_data)));
  // R6: same-cycle broadcast is captured at dispatch
  a_r6_bypass_j: assert property (@(posedge clk) disable iff (rst)
    (alloc && hit_dj) |=> (qj == '0 && vj == $past(cdb_data)));
  // R8: a station is freed only after it issued, and issues once
  a_r8_free_after_issue: assert property (@(posedge clk) disable iff (rst)
    free_me |-> issued);
  a_r8_single_issue: assert property (@(posedge clk) disable iff (rst)
    issue |=> !ready_o);
endmodule

// File: rtl/rs_array.sv
module rs_array #(
  parameter int unsigned N_ENT  = rs_pkg::DEF_ENTRIES,
  parameter int unsigned DATA_W = rs_pkg::DEF_DATA_W,
  parameter int unsigned OP_W   = rs_pkg::DEF_OP_W,
  localparam int unsigned TAG_W = rs_pkg::tag_bits(N_ENT),
  localparam int unsigned IDX_W = rs_pkg::idx_bits(N_ENT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              disp_valid,
  input  logic [OP_W-1:0]   disp_op,
  input  logic [TAG_W-1:0]  disp_qj,
  input  logic [DATA_W-1:0] disp_vj,
  input  logic [TAG_W-1:0]  disp_qk,
  input  logic [DATA_W-1:0] disp_vk,
  output logic              disp_ready,
  output logic [TAG_W-1:0]  disp_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  output logic              ex_valid,
  output logic [TAG_W-1:0]  ex_tag,
  output logic [OP_W-1:0]   ex_op,
  output logic [DATA_W-1:0] ex_vj,
  output logic [DATA_W-1:0] ex_vk
);
  logic [N_ENT-1:0]  busy_vec, ready_vec, free_gnt, sel_gnt, alloc_vec;
  logic [IDX_W-1:0]  free_idx, sel_idx;
  logic              free_any, sel_any;
  logic [OP_W-1:0]   op_arr [N_ENT];
  logic [DATA_W-1:0] vj_arr [N_ENT];
  logic [DATA_W-1:0] vk_arr [N_ENT];

  rs_pick #(.N(N_ENT)) u_free_pick (
    .req(~busy_vec), .gnt(free_gnt), .idx(free_idx), .any(free_any)
  );

  rs_pick #(.N(N_ENT)) u_sel_pick (
    .req(ready_vec), .gnt(sel_gnt), .idx(sel_idx), .any(sel_any)
  );

  assign alloc_vec  = disp_valid ? free_gnt : '0;
  assign disp_ready = free_any;
  assign disp_tag   = free_any ? (TAG_W'(free_idx) + TAG_W'(1)) : '0;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    rs_entry #(
      .DATA_W(DATA_W), .OP_W(OP_W), .TAG_W(TAG_W), .MY_TAG(g + 1)
    ) u_ent (
      .clk(clk), .rst(rst),
      .alloc(alloc_vec[g]),
      .d_op(disp_op), .d_qj(disp_qj), .d_vj(disp_vj),
      .d_qk(disp_qk), .d_vk(disp_vk),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
      .issue(sel_gnt[g]),
      .busy_o(busy_vec[g]), .ready_o(ready_vec[g]),
      .op_o(op_arr[g]), .vj_o(vj_arr[g]), .vk_o(vk_arr[g])
    );
  end

  logic [OP_W-1:0]   mux_op;
  logic [DATA_W-1:0] mux_vj, mux_vk;

  always_comb begin
    mux_op = '0;
    mux_vj = '0;
    mux_vk = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (sel_gnt[i]) begin
        mux_op = mux_op | op_arr[i];
        mux_vj = mux_vj | vj_arr[i];
        mux_vk = mux_vk | vk_arr[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_valid <= 1'b0;
      ex_tag   <= '0;
    end else begin
      ex_valid <= sel_any;
      if (sel_any) begin
        ex_tag <= TAG_W'(sel_idx) + TAG_W'(1);
        ex_op  <= mux_op;
        ex_vj  <= mux_vj;
        ex_vk  <= mux_vk;
      end
    end
  end

  // R7: at most one station granted per cycle
  a_r7_one_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_gnt));
  // R7: no ready station below the granted one
  a_r7_lowest_first: assert property (@(posedge clk) disable iff (rst)
    sel_any |-> ((ready_vec & (sel_gnt - N_ENT'(1))) == '0));
  // R1: a full array never offers a slot
  a_r1_full_blocks: assert property (@(posedge clk) disable iff (rst)
    (&busy_vec) |-> !disp_ready);
  // R10: no station is allocated while full
  a_r10_no_alloc_full: assert property (@(posedge clk) disable iff (rst)
    !disp_ready |-> (alloc_vec == '0));
endmodule

// File: tb/rs_array_tb_top.sv
module rs_array_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        disp_valid;
  logic [3:0]  disp_op;
  logic [2:0]  disp_qj, disp_qk;
  logic [31:0] disp_vj, disp_vk;
  logic        disp_ready;
  logic [2:0]  disp_tag;
  logic        cdb_valid;
  logic [2:0]  cdb_tag;
  logic [31:0] cdb_data;
  logic        ex_valid;
  logic [2:0]  ex_tag;
  logic [3:0]  ex_op;
  logic [31:0] ex_vj, ex_vk;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  rs_array #(.N_ENT(4), .DATA_W(32), .OP_W(4)) dut_i (
    .clk(clk), .rst(rst),
    .disp_valid(disp_valid), .disp_op(disp_op),
    .disp_qj(disp_qj), .disp_vj(disp_vj),
    .disp_qk(disp_qk), .disp_vk(disp_vk),
    .disp_ready(disp_ready), .disp_tag(disp_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .ex_valid(ex_valid), .ex_tag(ex_tag), .ex_op(ex_op),
    .ex_vj(ex_vj), .ex_vk(ex_vk)
  );

  // op, vj, vk : all dispatched with both sources present
  localparam logic [67:0] VEC [8] = '{
    {4'h1, 32'h0000_0011, 32'h0000_0022},
    {4'h2, 32'h3f80_0000, 32'h4000_0000},
    {4'h3, 32'hffff_ffff, 32'h0000_0000},
    {4'h4, 32'h1234_5678, 32'h9abc_def0},
    {4'h5, 32'h0000_0001, 32'h8000_0000},
    {4'h6, 32'hdead_beef, 32'h0bad_f00d},
    {4'h7, 32'h5555_5555, 32'haaaa_aaaa},
    {4'h8, 32'h0000_0100, 32'h0000_0200}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_ex(input string req, input logic [2:0] tag,
                        input logic [31:0] vj, input logic [31:0] vk);
    chk(req, "ex_valid", 32'(ex_valid), 32'd1);
    chk(req, "ex_tag", 32'(ex_tag), 32'(tag));
    chk(req, "ex_vj", ex_vj, vj);
    chk(req, "ex_vk", ex_vk, vk);
  endtask

  task automatic disp(input logic [3:0] op, input logic [2:0] qj,
                      input logic [31:0] vj, input logic [2:0] qk,
                      input logic [31:0] vk);
    disp_valid = 1'b1;
    disp_op = op; disp_qj = qj; disp_vj = vj; disp_qk = qk; disp_vk = vk;
    tick();
    disp_valid = 1'b0;
  endtask

  task automatic bcast(input logic [2:0] t, input logic [31:0] d);
    cdb_valid = 1'b1; cdb_tag = t; cdb_data = d;
    tick();
    cdb_valid = 1'b0; cdb_tag = '0;
  endtask

  // execution stub: returns a result for a finished station
  task automatic stub_done(input logic [2:0] t);
    bcast(t, 32'h0000_1000 + 32'(t));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    disp_valid = 1'b0; disp_op = '0; disp_qj = '0; disp_vj = '0;
    disp_qk = '0; disp_vk = '0;
    cdb_valid = 1'b0; cdb_tag = '0; cdb_data = '0;
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R9 reset state
    chk("R9", "ex_valid", 32'(ex_valid), 32'd0);
    chk("R9", "disp_ready", 32'(disp_ready), 32'd1);
    chk("R1", "disp_tag", 32'(disp_tag), 32'd1);

    // vector table: ready dispatches, issue next edge (R2, R5, R7)
    for (int i = 0; i < 8; i++) begin
      logic [3:0]  vop;
      logic [31:0] vj, vk;
      logic [2:0]  etag;
      vop  = VEC[i][67:64];
      vj   = VEC[i][63:32];
      vk   = VEC[i][31:0];
      etag = 3'((i % 4) + 1);
      chk("R1", "disp_tag", 32'(disp_tag), 32'(etag));
      disp(vop, 3'd0, vj, 3'd0, vk);
      tick();
      chk_ex("R2", etag, vj, vk);
      chk("R7", "ex_op", 32'(ex_op), 32'(vop));
      if ((i % 4) == 3) begin
        tick();
        chk("R8", "no reissue ex_valid", 32'(ex_valid), 32'd0);
        chk("R8", "still busy disp_ready", 32'(disp_ready), 32'd0);
        for (int t = 1; t <= 4; t++) stub_done(3'(t));
        chk("R8", "freed disp_ready", 32'(disp_ready), 32'd1);
      end
    end

    // waiting sources, wakeup and latency (R2, R3, R4, R5)
    disp(4'h9, 3'd5, 32'h0, 3'd0, 32'd10);
    disp(4'ha, 3'd5, 32'h0, 3'd6, 32'h0);
    tick();
    chk("R3", "waiting ex_valid", 32'(ex_valid), 32'd0);
    bcast(3'd5, 32'd100);
    chk("R5", "not before edge k+1", 32'(ex_valid), 32'd0);
    tick();
    chk_ex("R5", 3'd1, 32'd100, 32'd10);
    tick();
    chk("R3", "one source missing", 32'(ex_valid), 32'd0);
    bcast(3'd6, 32'd200);
    tick();
    chk_ex("R4", 3'd2, 32'd100, 32'd200);
    stub_done(3'd1);
    stub_done(3'd2);
    chk("R8", "disp_tag after free", 32'(disp_tag), 32'd1);

    // one broadcast wakes three, issued lowest first (R4, R7)
    for (int i = 0; i < 3; i++) disp(4'h2, 3'd5, 32'h0, 3'd0, 32'(i + 7));
    bcast(3'd5, 32'd42);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk_ex("R7", 3'(i + 1), 32'd42, 32'(i + 7));
    end
    tick();
    chk("R7", "drained", 32'(ex_valid), 32'd0);
    for (int t = 1; t <= 3; t++) stub_done(3'(t));

    // same-cycle broadcast captured at dispatch (R6)
    cdb_valid = 1'b1; cdb_tag = 3'd5; cdb_data = 32'd77;
    disp(4'h3, 3'd5, 32'h0, 3'd0, 32'd3);
    cdb_valid = 1'b0; cdb_tag = '0;
    tick();
    chk_ex("R6", 3'd1, 32'd77, 32'd3);
    cdb_valid = 1'b1; cdb_tag = 3'd6; cdb_data = 32'd55;
    disp(4'h3, 3'd0, 32'd1, 3'd6, 32'h0);
    cdb_valid = 1'b0; cdb_tag = '0;
    tick();
    chk_ex("R6", 3'd2, 32'd1, 32'd55);
    stub_done(3'd1);
    stub_done(3'd2);

    // full array, ignored dispatch, tag-0 broadcast (R10, R11, R8)
    for (int i = 0; i < 4; i++) disp(4'h4, 3'd6, 32'h0, 3'd0, 32'd9);
    chk("R1", "full disp_ready", 32'(disp_ready), 32'd0);
    chk("R1", "full disp_tag", 32'(disp_tag), 32'd0);
    disp(4'hf, 3'd0, 32'd1, 3'd0, 32'd2);
    tick();
    chk("R10", "ignored dispatch ex_valid", 32'(ex_valid), 32'd0);
    bcast(3'd0, 32'd999);
    tick();
    chk("R11", "tag 0 no wakeup", 32'(ex_valid), 32'd0);
    bcast(3'd6, 32'd50);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk_ex("R11", 3'(i + 1), 32'd50, 32'd9);
    end
    tick();
    chk("R8", "no reissue", 32'(ex_valid), 32'd0);
    chk("R8", "busy until broadcast", 32'(disp_ready), 32'd0);
    stub_done(3'd2);
    chk("R8", "freed one", 32'(disp_ready), 32'd1);
    chk("R8", "freed tag", 32'(disp_tag), 32'd2);
    stub_done(3'd1);
    stub_done(3'd3);
    stub_done(3'd4);
    chk("R1", "all free tag", 32'(disp_tag), 32'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule